// File: doc/BRIEF.md
# Multiplexed LCD Scan Level Sequencer

This block drives the timing side of a passive dot-matrix LCD panel with 16 common lines and 100 segment lines, run at 1/16 duty with a 1/5 bias drive. It counts cycles of the display oscillator clock. Each common line gets one slot of 24 clocks, so a full frame takes 384 clocks. In each slot the block presents a row address to the display latch and reads back that row's 100 pixel bits. For every common and segment output it then produces a 3-bit code that tells the analog switch bank which of six drive levels to connect.

The drive polarity alternates from one frame to the next, so the panel sees no net DC. The selected common and the pixel state together decide the level of each output. A display-enable input turns the panel dark. While it is low, every output is parked on the ground level, and the scan counters keep running underneath. Bias generation, the analog switches and the serial loading of the latch are outside this block.

Top module: `lcd_scan_seq`

## Requirements
- R1: While reset is asserted (synchronous, active low) every common and segment code is 5 (VSS), `row_addr` is 0 and `phase_neg` is 0; after reset is released the outputs stay at 5 until the first clock edge with reset high.
- R2: Each common slot lasts exactly 24 clocks: `row_addr` holds its value for 24 consecutive clock edges and changes only on the edge that ends a slot.
- R3: `row_addr` steps 0, 1, ..., 15 and then wraps to 0, so one frame is 384 clocks; counting restarts from 0 after any reset.
- R4: `phase_neg` is 0 in the first frame after reset and inverts on the edge where `row_addr` wraps from 15 to 0, so it toggles once every 384 clocks.
- R5: In a positive frame (`phase_neg`=0) with the display enabled, the common whose index equals the scanned row gets code 5 (VSS) and every other common gets code 1 (V1).
- R6: In a negative frame (`phase_neg`=1) with the display enabled, the scanned common gets code 0 (V0) and every other common gets code 4 (V4).
- R7: In a positive frame with the display enabled, segment i gets code 0 (V0) when bit i of `row_data` is 1 (pixel on) and code 2 (V2) when it is 0.
- R8: In a negative frame with the display enabled, segment i gets code 5 (VSS) when bit i of `row_data` is 1 and code 3 (V3) when it is 0.
- R9: When `disp_on` is low at a clock edge, every common and segment code becomes 5 after that edge; the slot and frame counters keep advancing during the inhibit.
- R10: All codes are registered. The codes after an edge reflect the `row_addr`, `phase_neg`, `row_data` and `disp_on` values present at that edge, so at a slot boundary the codes change one clock after `row_addr` does. With `row_data` and `disp_on` held, the codes do not change inside a slot.
- R11: Common codes are only ever 0, 1, 4 or 5. While the display is enabled, exactly one common carries the selecting level (5 or 0).
- R12: Segment codes are only ever 0, 2, 3 or 5.
- Code encoding: 0=V0, 1=V1, 2=V2, 3=V3, 4=V4, 5=VSS. Common i occupies bits [3i+2:3i] of `com_lvl`, and segment i occupies bits [3i+2:3i] of `seg_lvl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_on | input | 1 | High: normal drive; low: all outputs at VSS |
| row_data | input | 100 | Pixel bits of the latch row addressed by `row_addr` (1 = on) |
| row_addr | output | 4 | Common row currently being scanned |
| phase_neg | output | 1 | Drive polarity of the current frame (1 = negative) |
| com_lvl | output | 48 | Packed 3-bit level codes of the 16 commons |
| seg_lvl | output | 300 | Packed 3-bit level codes of the 100 segments |

## Verification
The scan is tried with four latch contents: all pixels off, all on, a checkerboard that alternates between neighbouring rows, and a single lit pixel that moves with the row. All-off against all-on separates the on and off segment levels in each polarity. The checkerboard catches a segment index or row read that is off by one. The walking pixel shows whether the segment codes follow the row being scanned and not a stale one. The runs cross the row wrap and the frame polarity flip. They also include an inhibit raised in the middle of a slot and a reset in the middle of a frame, which show that inhibit only masks the outputs while reset restarts the scan.

// File: rtl/lcd_scan_pkg.sv
// Package: shared level-code type and sizing defaults for the LCD scan sequencer.
// Assumes the analog switch bank decodes the 3-bit codes in the order listed.
package lcd_scan_pkg;

    localparam int LVL_W = 3;

    typedef enum logic [LVL_W-1:0] {
        LV_V0  = 3'd0,
        LV_V1  = 3'd1,
        LV_V2  = 3'd2,
        LV_V3  = 3'd3,
        LV_V4  = 3'd4,
        LV_VSS = 3'd5
    } lvl_t;

endpackage

// File: rtl/lcd_slot_timer.sv
// Module: lcd_slot_timer
// Counts oscillator clocks into slots of SLOT_CLKS, steps the scanned row once
// per slot and flips the drive polarity each time the row wraps.
// Assumes: synchronous active-low reset; N_COM >= 2, SLOT_CLKS >= 2.
module lcd_slot_timer #(
    parameter  int N_COM     = 16,
    parameter  int SLOT_CLKS = 24,
    localparam int ROW_W     = $clog2(N_COM),
    localparam int TICK_W    = $clog2(SLOT_CLKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [ROW_W-1:0] row_idx,
    output logic             phase_neg,
    output logic             slot_first
);

    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(SLOT_CLKS - 1);
    localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(N_COM - 1);

    logic [TICK_W-1:0] tick_q;
    logic              slot_end;
    logic              frame_end;

    // Slot and frame boundary detection.
    assign slot_end   = (tick_q == TICK_LAST);
    assign frame_end  = slot_end && (row_idx == ROW_LAST);
    assign slot_first = (tick_q == '0);

    // Clock counter within a slot.
    always_ff @(posedge clk) begin
        if (!rst_n)        tick_q <= '0;
        else if (slot_end) tick_q <= '0;
        else               tick_q <= tick_q + 1'b1;
    end

    // Row pointer: advances on slot end and wraps after the last common.
    always_ff @(posedge clk) begin
        if (!rst_n)         row_idx <= '0;
        else if (frame_end) row_idx <= '0;
        else if (slot_end)  row_idx <= row_idx + 1'b1;
    end

    // Frame polarity: inverts when the row pointer wraps.
    always_ff @(posedge clk) begin
        if (!rst_n)         phase_neg <= 1'b0;
        else if (frame_end) phase_neg <= ~phase_neg;
    end

    // Slot counter stays inside its range.
    assert_tick_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q <= TICK_LAST);

    // Row holds for the whole slot.
    assert_row_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_q != TICK_LAST) |=> $stable(row_idx));

    // Row steps by one at the end of an inner slot.
    assert_row_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_q == TICK_LAST && row_idx != ROW_LAST) |=> (row_idx == $past(row_idx) + 1'b1));

    // Row wraps and polarity flips at frame end.
    assert_frame_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_q == TICK_LAST && row_idx == ROW_LAST) |=> (row_idx == '0 && phase_neg != $past(phase_neg)));

    // Polarity is steady away from frame ends.
    assert_phase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_q == TICK_LAST && row_idx == ROW_LAST) |=> $stable(phase_neg));

endmodule

// File: rtl/lcd_com_encoder.sv
// Module: lcd_com_encoder
// Chooses the next level code of every common line from the scanned row,
// the frame polarity and the display-enable flag. Purely combinational.
// Assumes the caller registers the result.
module lcd_com_encoder
    import lcd_scan_pkg::*;
#(
    parameter  int N_COM = 16,
    localparam int ROW_W = $clog2(N_COM)
) (
    input  logic                   show,
    input  logic                   phase_neg,
    input  logic [ROW_W-1:0]       row_idx,
    output logic [N_COM*LVL_W-1:0] com_next
);

    for (genvar gi = 0; gi < N_COM; gi++) begin : g_com
        lvl_t code;
        // Level for common gi: select or non-select voltage by polarity.
        always_comb begin
            if (!show)                        code = LV_VSS;
            else if (row_idx == ROW_W'(gi))   code = phase_neg ? LV_V0 : LV_VSS;
            else                              code = phase_neg ? LV_V4 : LV_V1;
        end
        assign com_next[gi*LVL_W +: LVL_W] = code;
    end

endmodule

// File: rtl/lcd_seg_encoder.sv
// Module: lcd_seg_encoder
// Chooses the next level code of every segment line from the pixel bits of
// the scanned row, the polarity and the display-enable flag. Combinational.
// Assumes a pixel bit of 1 means the dot is on.
module lcd_seg_encoder
    import lcd_scan_pkg::*;
#(
    parameter int N_SEG = 100
) (
    input  logic                   show,
    input  logic                   phase_neg,
    input  logic [N_SEG-1:0]       pixels,
    output logic [N_SEG*LVL_W-1:0] seg_next
);

    for (genvar gi = 0; gi < N_SEG; gi++) begin : g_seg
        lvl_t code;
        // Level for segment gi: on or off voltage by polarity.
        always_comb begin
            if (!show)           code = LV_VSS;
            else if (pixels[gi]) code = phase_neg ? LV_VSS : LV_V0;
            else                 code = phase_neg ? LV_V3  : LV_V2;
        end
        assign seg_next[gi*LVL_W +: LVL_W] = code;
    end

endmodule

// File: rtl/lcd_scan_seq.sv
// Module: lcd_scan_seq (top)
// 1/16-duty, 1/5-bias scan sequencer: runs the slot timer, addresses the
// display latch, encodes common and segment levels and registers them.
// Assumes row_data is the latch row selected by row_addr in the same cycle.
module lcd_scan_seq
    import lcd_scan_pkg::*;
#(
    parameter  int N_COM     = 16,
    parameter  int N_SEG     = 100,
    parameter  int SLOT_CLKS = 24,
    localparam int ROW_W     = $clog2(N_COM)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   disp_on,
    input  logic [N_SEG-1:0]       row_data,
    output logic [ROW_W-1:0]       row_addr,
    output logic                   phase_neg,
    output logic [N_COM*LVL_W-1:0] com_lvl,
    output logic [N_SEG*LVL_W-1:0] seg_lvl
);

    localparam logic [N_COM*LVL_W-1:0] COM_IDLE = {N_COM{LV_VSS}};
    localparam logic [N_SEG*LVL_W-1:0] SEG_IDLE = {N_SEG{LV_VSS}};

    logic                   slot_first;
    logic [N_COM*LVL_W-1:0] com_next;
    logic [N_SEG*LVL_W-1:0] seg_next;

    lcd_slot_timer #(
        .N_COM     (N_COM),
        .SLOT_CLKS (SLOT_CLKS)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .row_idx    (row_addr),
        .phase_neg  (phase_neg),
        .slot_first (slot_first)
    );

    lcd_com_encoder #(
        .N_COM (N_COM)
    ) u_com (
        .show      (disp_on),
        .phase_neg (phase_neg),
        .row_idx   (row_addr),
        .com_next  (com_next)
    );

    lcd_seg_encoder #(
        .N_SEG (N_SEG)
    ) u_seg (
        .show      (disp_on),
        .phase_neg (phase_neg),
        .pixels    (row_data),
        .seg_next  (seg_next)
    );

    // Output register for all level codes; reset parks them on VSS.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            com_lvl <= COM_IDLE;
            seg_lvl <= SEG_IDLE;
        end else begin
            com_lvl <= com_next;
            seg_lvl <= seg_next;
        end
    end

    // Per-line flags used by the checks below.
    logic [N_COM-1:0] com_sel_hit;
    logic [N_COM-1:0] com_legal;
    logic [N_SEG-1:0] seg_legal;

    for (genvar gi = 0; gi < N_COM; gi++) begin : g_comchk
        logic [LVL_W-1:0] c;
        assign c = com_lvl[gi*LVL_W +: LVL_W];
        assign com_sel_hit[gi] = (c == LV_VSS) || (c == LV_V0);
        assign com_legal[gi]   = (c == LV_V0) || (c == LV_V1) || (c == LV_V4) || (c == LV_VSS);
    end

    for (genvar gi = 0; gi < N_SEG; gi++) begin : g_segchk
        logic [LVL_W-1:0] s;
        assign s = seg_lvl[gi*LVL_W +: LVL_W];
        assign seg_legal[gi] = (s == LV_V0) || (s == LV_V2) || (s == LV_V3) || (s == LV_VSS);
    end

    // Inhibit sampled at an edge parks every output on VSS.
    assert_inhibit_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_on |=> (com_lvl == COM_IDLE && seg_lvl == SEG_IDLE));

    // Codes do not move inside a slot when their inputs are held.
    assert_midslot_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_first && $stable(row_data) && $stable(disp_on)) |=> ($stable(com_lvl) && $stable(seg_lvl)));

    // Common codes stay within the common level set.
    assert_com_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        com_legal == {N_COM{1'b1}});

    // Exactly one common carries the selecting level while shown.
    assert_com_onesel_R11: assert property (@(posedge clk) disable iff (!rst_n)
        disp_on |=> $onehot(com_sel_hit));

    // Segment codes stay within the segment level set.
    assert_seg_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
        seg_legal == {N_SEG{1'b1}});

endmodule

// File: tb/tb_lcd_scan_seq.sv
module tb_lcd_scan_seq;

    localparam int N_COM = 16;
    localparam int N_SEG = 100;
    localparam int SLOT  = 24;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 disp_on = 1'b0;
    logic [N_SEG-1:0]     mem [N_COM];
    logic [N_SEG-1:0]     row_data;
    logic [3:0]           row_addr;
    logic                 phase_neg;
    logic [N_COM*3-1:0]   com_lvl;
    logic [N_SEG*3-1:0]   seg_lvl;

    int n_checks = 0;
    int n_fails  = 0;
    int n_edges  = 0;     // edges with reset high since the last reset
    logic on_at_edge = 1'b0;

    always #5 clk = ~clk;

    assign row_data = mem[row_addr];

    lcd_scan_seq dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .disp_on   (disp_on),
        .row_data  (row_data),
        .row_addr  (row_addr),
        .phase_neg (phase_neg),
        .com_lvl   (com_lvl),
        .seg_lvl   (seg_lvl)
    );

    task automatic check(input bit ok, input string req, input logic [299:0] act, input logic [299:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // One clock: advance, record what the design sampled, then check at negedge.
    task automatic step_check();
        int slot_now, slot_out, row_out;
        bit neg_out;
        logic [N_COM*3-1:0] ec;
        logic [N_SEG*3-1:0] es;
        string rc, rs;
        @(posedge clk);
        on_at_edge = disp_on;
        if (rst_n) n_edges++; else n_edges = 0;
        @(negedge clk);
        slot_now = n_edges / SLOT;
        check(row_addr == 4'(slot_now % N_COM), "R3 row_addr", 300'(row_addr), 300'(slot_now % N_COM));
        check(phase_neg == 1'((slot_now / N_COM) % 2), "R4 phase_neg", 300'(phase_neg), 300'((slot_now / N_COM) % 2));
        if (n_edges == 0 || !on_at_edge) begin
            ec = {N_COM{3'd5}};
            es = {N_SEG{3'd5}};
            rc = (n_edges == 0) ? "R1 com idle" : "R9 com inhibit";
            rs = (n_edges == 0) ? "R1 seg idle" : "R9 seg inhibit";
        end else begin
            slot_out = (n_edges - 1) / SLOT;
            row_out  = slot_out % N_COM;
            neg_out  = 1'((slot_out / N_COM) % 2);
            for (int i = 0; i < N_COM; i++)
                ec[i*3 +: 3] = (i == row_out) ? (neg_out ? 3'd0 : 3'd5) : (neg_out ? 3'd4 : 3'd1);
            for (int i = 0; i < N_SEG; i++)
                es[i*3 +: 3] = mem[row_out][i] ? (neg_out ? 3'd5 : 3'd0) : (neg_out ? 3'd3 : 3'd2);
            rc = neg_out ? "R6 com neg" : "R5 com pos";
            rs = neg_out ? "R8 seg neg" : "R7 seg pos";
        end
        check(com_lvl == ec, rc, 300'(com_lvl), 300'(ec));
        check(seg_lvl == es, rs, seg_lvl, es);
    endtask

    task automatic fill(input int kind);
        for (int r = 0; r < N_COM; r++)
            for (int i = 0; i < N_SEG; i++)
                case (kind)
                    0: mem[r][i] = 1'b0;
                    1: mem[r][i] = 1'b1;
                    2: mem[r][i] = 1'((i + r) % 2);
                    default: mem[r][i] = (i == (r * 6) % N_SEG);
                endcase
    endtask

    // R1: reset state held for several edges.
    task automatic t_reset();
        rst_n = 1'b0;
        for (int k = 0; k < 4; k++) step_check();
        rst_n = 1'b1;
    endtask

    // R2 R3 R5 R6 R7 R8 R10: scan one frame with a given pattern.
    task automatic t_scan(input int kind);
        fill(kind);
        for (int k = 0; k < SLOT * N_COM; k++) step_check();
    endtask

    // R9: inhibit raised mid-slot, counters keep running, then released.
    task automatic t_inhibit();
        for (int k = 0; k < 7; k++) step_check();
        disp_on = 1'b0;
        for (int k = 0; k < 40; k++) step_check();
        disp_on = 1'b1;
        for (int k = 0; k < 30; k++) step_check();
    endtask

    // R3 R10: mid-slot row data change shows one clock later.
    task automatic t_midslot_data();
        for (int k = 0; k < 5; k++) step_check();
        fill(1);
        for (int k = 0; k < 30; k++) step_check();
    endtask

    // R1 R3: reset in the middle of a frame restarts the scan.
    task automatic t_restart();
        for (int k = 0; k < 100; k++) step_check();
        rst_n = 1'b0;
        step_check();
        step_check();
        rst_n = 1'b1;
        for (int k = 0; k < 60; k++) step_check();
    endtask

    initial begin
        fill(0);
        @(negedge clk);
        t_reset();
        disp_on = 1'b1;
        t_scan(0);
        t_scan(1);
        t_scan(2);
        t_scan(3);
        t_inhibit();
        fill(0);
        t_midslot_data();
        t_restart();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #2000000;
        n_fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule